// File: doc/BRIEF.md
# Speculative Load Ordering Guard

This block tracks loads that a core has executed ahead of an older load in program order. The load stays tracked from execution until it commits. Each tracked load has one slot in a small circular table. The slot holds the cache block address the load read and the value that came back. Slots are handed out in program order, and the slot index serves as the load's tag. A commit pulse retires the oldest slot.

The block runs in one of two modes, chosen by a static input.

- **Snoop mode.** Every slot is compared against two inputs: blocks the private L1 evicts, and incoming requests from other cores for write ownership. A hit on any slot squashes that load and every younger one. Another core could then have seen the out-of-order result. A request for shared read permission never squashes.
- **Replay mode.** Evictions and snoops are ignored. The load is read again at commit, and the new value is compared with the stored one. Any difference squashes the oldest load and everything younger.

A squash removes the squashed slots from the table. It is reported one cycle later with the tag of the oldest squashed load. The pipeline treats that tag and every later tag as squashed.

Top module: `spec_load_guard`

## Requirements
- R1: After reset the table is empty. occupancy is 0, full is 0, squash_valid and commit_done are 0, and alloc_tag is 0.
- R2: Each accepted alloc_valid gets tag alloc_tag. Tags count upward by one from 0 and wrap modulo 8. Once 8 loads are tracked, full is 1 and a further alloc_valid is ignored: occupancy stays 8.
- R3: An eviction whose address lies in the same block as a tracked load squashes that load and all younger loads. On the next cycle squash_valid is 1, squash_tag is the matched tag, and occupancy equals the number of older loads still tracked.
- R4: In snoop mode, snoop_valid with snoop_excl=1 (a write-ownership request) to a tracked block squashes in the same way as R3.
- R5: A snoop with snoop_excl=0 (a shared read request) never causes a squash.
- R6: Addresses match on 64-byte blocks. Address bits [5:0] are ignored, and a difference in bit 6 or above is not a match.
- R7: When several tracked loads match in one cycle, squash_tag is the tag of the oldest match.
- R8: commit_valid retires the oldest load. On the next cycle commit_done is 1 and commit_tag is that load's tag, and occupancy drops by one. commit_valid on an empty table is ignored.
- R9: If the oldest load is squashed in the same cycle as commit_valid, the squash wins. commit_done stays 0, squash_tag is the oldest tag, and the table empties.
- R10: In replay mode (replay_mode=1), commit_data equal to the stored value commits normally. Unequal commit_data squashes the oldest load and all younger loads, and commit_done stays 0.
- R11: In replay mode, evictions and ownership snoops cause no squash.
- R12: An alloc_valid in the same cycle as a squash is discarded, because it is younger than every squashed load.
- R13: In snoop mode, commit_data has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| replay_mode | input | 1 | 0 = snoop mode, 1 = replay mode (static) |
| alloc_valid | input | 1 | A speculative load executed |
| alloc_addr | input | 48 | Byte address the load read |
| alloc_data | input | 64 | Value the load returned |
| alloc_tag | output | 3 | Tag the next accepted load receives |
| evict_valid | input | 1 | L1 evicts a block |
| evict_addr | input | 48 | Address inside the evicted block |
| snoop_valid | input | 1 | Incoming coherence request |
| snoop_excl | input | 1 | 1 = write ownership, 0 = shared read |
| snoop_addr | input | 48 | Address of the requested block |
| commit_valid | input | 1 | Oldest tracked load commits |
| commit_data | input | 64 | Value re-read at commit (replay mode) |
| commit_done | output | 1 | A load retired without squash |
| commit_tag | output | 3 | Tag of the retired load |
| squash_valid | output | 1 | Loads were squashed |
| squash_tag | output | 3 | Oldest squashed tag; all later tags are also squashed |
| occupancy | output | 4 | Number of tracked loads |
| full | output | 1 | Table holds 8 loads |

## Verification
The table is first filled with more than eight loads and then drained. This shows whether tag order, wrap-around and the full limit behave correctly. Conflicts are then placed on the oldest, a middle and the youngest slot, and on two slots at once. These cases separate "squash this one" from "squash this and all younger", and show whether the oldest match is picked. Shared requests and addresses that differ only in offset bits or in bit 6 test the match filter. Commits raced against conflicts on the oldest slot and on a younger slot, plus replay commits with equal and unequal values, show whether squash wins and which mode is active.

// File: rtl/slg_pkg.sv
package slg_pkg;

  typedef enum logic {
    MODE_SNOOP  = 1'b0,
    MODE_REPLAY = 1'b1
  } guard_mode_e;

  // Distance of a slot from the oldest slot, modulo the table depth.
  function automatic int unsigned slot_age(input int unsigned slot,
                                           input int unsigned oldest,
                                           input int unsigned depth);
    return (slot + depth - oldest) % depth;
  endfunction

  // Slot reached by stepping forward from the oldest slot.
  function automatic int unsigned slot_at(input int unsigned oldest,
                                          input int unsigned age,
                                          input int unsigned depth);
    return (oldest + age) % depth;
  endfunction

endpackage

// File: rtl/slg_ptr_ctrl.sv
module slg_ptr_ctrl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             commit_fire,
  input  logic             kill_any,
  input  logic [IDX_W-1:0] kill_age,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic [CNT_W-1:0] occ_q,
  output logic [DEPTH-1:0] live_vec
);
  import slg_pkg::*;

  logic [IDX_W-1:0] head_n;
  logic [CNT_W-1:0] occ_n;

  always_comb begin
    head_n = head_idx;
    occ_n  = occ_q;
    if (commit_fire) head_n = IDX_W'(slot_at(head_idx, 1, DEPTH));
    if (kill_any) begin
      occ_n = CNT_W'(kill_age) - (commit_fire ? CNT_W'(1) : CNT_W'(0));
    end else begin
      occ_n = occ_q + (alloc_fire ? CNT_W'(1) : CNT_W'(0))
                    - (commit_fire ? CNT_W'(1) : CNT_W'(0));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_idx <= '0;
      occ_q    <= '0;
    end else begin
      head_idx <= head_n;
      occ_q    <= occ_n;
    end
  end

  assign tail_idx = IDX_W'(slot_at(head_idx, occ_q, DEPTH));

  for (genvar s = 0; s < DEPTH; s++) begin : g_live
    assign live_vec[s] = (slot_age(s, head_idx, DEPTH) < occ_q);
  end

endmodule

// File: rtl/slg_match_array.sv
module slg_match_array #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned BLK_W  = 42,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BLK_W-1:0]  wr_blk,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DEPTH-1:0]  live_vec,
  input  logic              watch_en,
  input  logic              evict_en,
  input  logic [BLK_W-1:0]  evict_blk,
  input  logic              own_en,
  input  logic [BLK_W-1:0]  own_blk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [DEPTH-1:0]  hit_vec
);

  logic [BLK_W-1:0]  blk_q  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic evict_hit;
    logic own_hit;

    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(s))) begin
        blk_q[s]  <= wr_blk;
        data_q[s] <= wr_data;
      end
    end

    assign evict_hit  = evict_en && (evict_blk == blk_q[s]);
    assign own_hit    = own_en && (own_blk == blk_q[s]);
    assign hit_vec[s] = watch_en && live_vec[s] && (evict_hit || own_hit);
  end

  assign rd_data = data_q[rd_idx];

endmodule

// File: rtl/slg_oldest_pick.sv
module slg_oldest_pick #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] kill_vec,
  input  logic [IDX_W-1:0] head_idx,
  output logic             kill_any,
  output logic [IDX_W-1:0] kill_age
);
  import slg_pkg::*;

  // Walk from youngest to oldest so the oldest match is assigned last.
  always_comb begin
    kill_any = 1'b0;
    kill_age = '0;
    for (int a = DEPTH - 1; a >= 0; a--) begin
      if (kill_vec[slot_at(head_idx, a, DEPTH)]) begin
        kill_any = 1'b1;
        kill_age = IDX_W'(a);
      end
    end
  end

endmodule

// File: rtl/spec_load_guard.sv
module spec_load_guard #(
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned ADDR_W    = 48,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned BLK_BYTES = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned OFF_W = $clog2(BLK_BYTES),
  localparam int unsigned BLK_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              replay_mode,
  input  logic              alloc_valid,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [DATA_W-1:0] alloc_data,
  output logic [IDX_W-1:0]  alloc_tag,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic              snoop_valid,
  input  logic              snoop_excl,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              commit_valid,
  input  logic [DATA_W-1:0] commit_data,
  output logic              commit_done,
  output logic [IDX_W-1:0]  commit_tag,
  output logic              squash_valid,
  output logic [IDX_W-1:0]  squash_tag,
  output logic [CNT_W-1:0]  occupancy,
  output logic              full
);
  import slg_pkg::*;

  guard_mode_e       mode;
  logic [IDX_W-1:0]  head_idx;
  logic [IDX_W-1:0]  tail_idx;
  logic [CNT_W-1:0]  occ_q;
  logic [DEPTH-1:0]  live_vec;
  logic [DEPTH-1:0]  hit_vec;
  logic [DEPTH-1:0]  kill_vec;
  logic [DATA_W-1:0] head_data;
  logic              table_empty;
  logic              replay_miss;
  logic              kill_any;
  logic [IDX_W-1:0]  kill_age;
  logic              kill_at_head;
  logic              commit_fire;
  logic              alloc_fire;

  assign mode        = guard_mode_e'(replay_mode);
  assign table_empty = (occ_q == '0);
  assign full        = (occ_q == CNT_W'(DEPTH));
  assign occupancy   = occ_q;
  assign alloc_tag   = tail_idx;

  slg_match_array #(
    .DEPTH (DEPTH),
    .BLK_W (BLK_W),
    .DATA_W(DATA_W)
  ) u_array (
    .clk      (clk),
    .wr_en    (alloc_fire),
    .wr_idx   (tail_idx),
    .wr_blk   (alloc_addr[ADDR_W-1:OFF_W]),
    .wr_data  (alloc_data),
    .live_vec (live_vec),
    .watch_en (mode == MODE_SNOOP),
    .evict_en (evict_valid),
    .evict_blk(evict_addr[ADDR_W-1:OFF_W]),
    .own_en   (snoop_valid && snoop_excl),
    .own_blk  (snoop_addr[ADDR_W-1:OFF_W]),
    .rd_idx   (head_idx),
    .rd_data  (head_data),
    .hit_vec  (hit_vec)
  );

  assign replay_miss = (mode == MODE_REPLAY) && commit_valid && !table_empty
                       && (head_data != commit_data);
  assign kill_vec    = hit_vec | (replay_miss ? (DEPTH'(1) << head_idx) : '0);

  slg_oldest_pick #(.DEPTH(DEPTH)) u_pick (
    .kill_vec(kill_vec),
    .head_idx(head_idx),
    .kill_any(kill_any),
    .kill_age(kill_age)
  );

  assign kill_at_head = kill_vec[head_idx];
  assign commit_fire  = commit_valid && !table_empty && !kill_at_head;
  assign alloc_fire   = alloc_valid && !full && !kill_any;

  slg_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_fire (alloc_fire),
    .commit_fire(commit_fire),
    .kill_any   (kill_any),
    .kill_age   (kill_age),
    .head_idx   (head_idx),
    .tail_idx   (tail_idx),
    .occ_q      (occ_q),
    .live_vec   (live_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit_done  <= 1'b0;
      commit_tag   <= '0;
      squash_valid <= 1'b0;
      squash_tag   <= '0;
    end else begin
      commit_done  <= commit_fire;
      commit_tag   <= head_idx;
      squash_valid <= kill_any;
      squash_tag   <= IDX_W'(slot_at(head_idx, kill_age, DEPTH));
    end
  end

endmodule

// File: rtl/slg_checker.sv
module slg_checker #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             replay_mode,
  input logic             commit_valid,
  input logic             evict_valid,
  input logic             snoop_valid,
  input logic             snoop_excl,
  input logic             commit_done,
  input logic [IDX_W-1:0] commit_tag,
  input logic             squash_valid,
  input logic [IDX_W-1:0] squash_tag,
  input logic [CNT_W-1:0] occupancy,
  input logic [IDX_W-1:0] head_idx,
  input logic             kill_any,
  input logic             kill_at_head
);

  a_r2_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CNT_W'(DEPTH));

  a_r2_grow_one: assert property (@(posedge clk) disable iff (!rst_n)
    !kill_any |=> ({1'b0, occupancy} <= {1'b0, $past(occupancy)} + (CNT_W+1)'(1)));

  a_r12_squash_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    kill_any |=> (occupancy < $past(occupancy)));

  a_r9_squash_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && kill_at_head) |=>
      (!commit_done && squash_valid && squash_tag == $past(head_idx)));

  a_r8_commit_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |-> (commit_tag == $past(head_idx)));

  a_r8_empty_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && occupancy == '0) |=> !commit_done);

  a_r5_quiet_snoop_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (!replay_mode && !evict_valid && !(snoop_valid && snoop_excl)) |=> !squash_valid);

  a_r11_replay_blind: assert property (@(posedge clk) disable iff (!rst_n)
    (replay_mode && !commit_valid) |=> !squash_valid);

  a_r3_disjoint_tags: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_valid && commit_done) |-> (squash_tag != commit_tag));

endmodule

bind spec_load_guard slg_checker #(.DEPTH(DEPTH)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .replay_mode (replay_mode),
  .commit_valid(commit_valid),
  .evict_valid (evict_valid),
  .snoop_valid (snoop_valid),
  .snoop_excl  (snoop_excl),
  .commit_done (commit_done),
  .commit_tag  (commit_tag),
  .squash_valid(squash_valid),
  .squash_tag  (squash_tag),
  .occupancy   (occupancy),
  .head_idx    (head_idx),
  .kill_any    (kill_any),
  .kill_at_head(kill_at_head)
);

// File: tb/test_spec_load_guard.sv
module test_spec_load_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        replay_mode = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [47:0] alloc_addr = '0;
  logic [63:0] alloc_data = '0;
  logic [2:0]  alloc_tag;
  logic        evict_valid = 1'b0;
  logic [47:0] evict_addr = '0;
  logic        snoop_valid = 1'b0;
  logic        snoop_excl = 1'b0;
  logic [47:0] snoop_addr = '0;
  logic        commit_valid = 1'b0;
  logic [63:0] commit_data = '0;
  logic        commit_done;
  logic [2:0]  commit_tag;
  logic        squash_valid;
  logic [2:0]  squash_tag;
  logic [3:0]  occupancy;
  logic        full;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  spec_load_guard i_spec_load_guard (
    .clk(clk), .rst_n(rst_n), .replay_mode(replay_mode),
    .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_data(alloc_data),
    .alloc_tag(alloc_tag),
    .evict_valid(evict_valid), .evict_addr(evict_addr),
    .snoop_valid(snoop_valid), .snoop_excl(snoop_excl), .snoop_addr(snoop_addr),
    .commit_valid(commit_valid), .commit_data(commit_data),
    .commit_done(commit_done), .commit_tag(commit_tag),
    .squash_valid(squash_valid), .squash_tag(squash_tag),
    .occupancy(occupancy), .full(full)
  );

  function automatic logic [47:0] addr_of(input int blk, input int low);
    return (48'(blk) << 6) | 48'(low & 63);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle();
    alloc_valid = 0; evict_valid = 0; snoop_valid = 0; snoop_excl = 0; commit_valid = 0;
  endtask

  task automatic alloc_one(input int blk, input logic [63:0] d, input int exp_tag, input string req);
    alloc_valid = 1; alloc_addr = addr_of(blk, 0); alloc_data = d;
    chk(req, "alloc_tag", int'(alloc_tag), exp_tag);
    cyc(); idle();
  endtask

  task automatic commit_one(input int exp_tag, input string req);
    commit_valid = 1;
    cyc(); idle();
    chk(req, "commit_done", int'(commit_done), 1);
    chk(req, "commit_tag", int'(commit_tag), exp_tag);
    chk(req, "no squash at commit", int'(squash_valid), 0);
  endtask

  task automatic t_reset();
    chk("R1", "occupancy", int'(occupancy), 0);
    chk("R1", "full", int'(full), 0);
    chk("R1", "squash_valid", int'(squash_valid), 0);
    chk("R1", "commit_done", int'(commit_done), 0);
    chk("R1", "alloc_tag", int'(alloc_tag), 0);
  endtask

  task automatic t_fill_drain();
    for (int k = 0; k < 8; k++) alloc_one(100 + 2 * k, 64'(k), k, "R2");
    chk("R2", "full", int'(full), 1);
    chk("R2", "occupancy", int'(occupancy), 8);
    alloc_valid = 1; alloc_addr = addr_of(200, 0);
    cyc(); idle();
    chk("R2", "occupancy after alloc when full", int'(occupancy), 8);
    for (int k = 0; k < 8; k++) commit_one(k, "R8");
    chk("R8", "occupancy drained", int'(occupancy), 0);
    commit_valid = 1;
    cyc(); idle();
    chk("R8", "commit on empty", int'(commit_done), 0);
    chk("R2", "tag wraps to 0", int'(alloc_tag), 0);
  endtask

  task automatic t_evict();
    for (int k = 0; k < 4; k++) alloc_one(10 + k, 64'(k), k, "R2");
    evict_valid = 1; evict_addr = addr_of(11, 6'h2a);
    cyc(); idle();
    chk("R3", "squash_valid", int'(squash_valid), 1);
    chk("R3", "squash_tag", int'(squash_tag), 1);
    chk("R3", "occupancy", int'(occupancy), 1);
    chk("R6", "low bits ignored gives squash", int'(squash_valid), 1);
    commit_one(0, "R8");
  endtask

  task automatic t_excl();
    alloc_one(20, 64'h1, 1, "R2");
    alloc_one(22, 64'h2, 2, "R2");
    alloc_one(24, 64'h3, 3, "R2");
    snoop_valid = 1; snoop_excl = 1; snoop_addr = addr_of(24, 6'h3f);
    cyc(); idle();
    chk("R4", "squash_valid", int'(squash_valid), 1);
    chk("R4", "squash_tag", int'(squash_tag), 3);
    chk("R4", "occupancy", int'(occupancy), 2);
    snoop_valid = 1; snoop_excl = 0; snoop_addr = addr_of(20, 0);
    cyc(); idle();
    chk("R5", "shared snoop squash_valid", int'(squash_valid), 0);
    chk("R5", "shared snoop occupancy", int'(occupancy), 2);
    snoop_valid = 1; snoop_excl = 1; snoop_addr = addr_of(20, 0) ^ 48'h40;
    cyc(); idle();
    chk("R6", "bit 6 differs squash_valid", int'(squash_valid), 0);
    chk("R6", "bit 6 differs occupancy", int'(occupancy), 2);
    commit_one(1, "R8");
    commit_one(2, "R8");
  endtask

  task automatic t_multi();
    alloc_one(30, 64'h1, 3, "R2");
    alloc_one(32, 64'h2, 4, "R2");
    alloc_one(34, 64'h3, 5, "R2");
    evict_valid = 1; evict_addr = addr_of(34, 0);
    snoop_valid = 1; snoop_excl = 1; snoop_addr = addr_of(32, 5);
    cyc(); idle();
    chk("R7", "squash_tag oldest", int'(squash_tag), 4);
    chk("R7", "occupancy", int'(occupancy), 1);
    commit_one(3, "R8");
  endtask

  task automatic t_race_head();
    alloc_one(50, 64'h1, 4, "R2");
    alloc_one(52, 64'h2, 5, "R2");
    commit_valid = 1; evict_valid = 1; evict_addr = addr_of(50, 9);
    cyc(); idle();
    chk("R9", "commit_done", int'(commit_done), 0);
    chk("R9", "squash_valid", int'(squash_valid), 1);
    chk("R9", "squash_tag", int'(squash_tag), 4);
    chk("R9", "occupancy", int'(occupancy), 0);
  endtask

  task automatic t_race_young();
    alloc_one(54, 64'h1, 4, "R2");
    alloc_one(56, 64'h2, 5, "R2");
    commit_valid = 1; snoop_valid = 1; snoop_excl = 1; snoop_addr = addr_of(56, 0);
    cyc(); idle();
    chk("R8", "commit_done", int'(commit_done), 1);
    chk("R8", "commit_tag", int'(commit_tag), 4);
    chk("R4", "squash_tag", int'(squash_tag), 5);
    chk("R4", "occupancy", int'(occupancy), 0);
  endtask

  task automatic t_alloc_in_squash();
    alloc_one(60, 64'h1, 5, "R2");
    alloc_one(62, 64'h2, 6, "R2");
    alloc_valid = 1; alloc_addr = addr_of(64, 0);
    evict_valid = 1; evict_addr = addr_of(62, 0);
    cyc(); idle();
    chk("R12", "squash_tag", int'(squash_tag), 6);
    chk("R12", "occupancy", int'(occupancy), 1);
    chk("R12", "alloc_tag reused", int'(alloc_tag), 6);
    commit_one(5, "R8");
  endtask

  task automatic t_commit_data_snoop();
    alloc_one(70, 64'h11, 6, "R2");
    commit_valid = 1; commit_data = 64'hdead;
    cyc(); idle();
    chk("R13", "commit_done", int'(commit_done), 1);
    chk("R13", "commit_tag", int'(commit_tag), 6);
    chk("R13", "squash_valid", int'(squash_valid), 0);
  endtask

  task automatic t_replay();
    replay_mode = 1;
    alloc_one(80, 64'haaaa, 7, "R2");
    alloc_one(82, 64'hbbbb, 0, "R2");
    alloc_one(84, 64'hcccc, 1, "R2");
    evict_valid = 1; evict_addr = addr_of(80, 0);
    snoop_valid = 1; snoop_excl = 1; snoop_addr = addr_of(82, 0);
    cyc(); idle();
    chk("R11", "squash_valid", int'(squash_valid), 0);
    chk("R11", "occupancy", int'(occupancy), 3);
    commit_valid = 1; commit_data = 64'haaaa;
    cyc(); idle();
    chk("R10", "equal commit_done", int'(commit_done), 1);
    chk("R10", "equal commit_tag", int'(commit_tag), 7);
    commit_valid = 1; commit_data = 64'hbbba;
    cyc(); idle();
    chk("R10", "mismatch commit_done", int'(commit_done), 0);
    chk("R10", "mismatch squash_valid", int'(squash_valid), 1);
    chk("R10", "mismatch squash_tag", int'(squash_tag), 0);
    chk("R10", "mismatch occupancy", int'(occupancy), 0);
    replay_mode = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    t_reset();
    t_fill_drain();
    t_evict();
    t_excl();
    t_multi();
    t_race_head();
    t_race_young();
    t_alloc_in_squash();
    t_commit_data_snoop();
    t_replay();
    cyc();
    finish_run();
  end

endmodule